// File: doc/BRIEF.md
# Framed SPI Register Slave with Error Monitoring

This block is a serial slave that lets an external host read and write a small register file over a four-signal SPI link. The link uses an active-low select, a serial clock that idles low, a host-to-slave data line and a slave-to-host data line. Every transfer is one fixed-width frame sent most significant bit first. The host samples on the falling clock edge. The slave shifts its next bit out after that same edge, so its output stays stable across the following rising edge.

A command frame carries a direction bit, an address and an even parity bit. The block acts on a frame only when select is released. At that point it presents the address to the register file and samples the reply. It sends the reply during the next frame, so every answer is one frame late. A write takes two frames: the command frame, then a data frame. The frame that follows the command returns the old register contents, and the frame that follows the data frame returns the new contents. The block has three sticky error bits: a parity mismatch, a wrong number of clock pulses, and an address that the register file does not decode. It also has a summary error flag, which is returned inside every reply. All of these are cleared by one special read.

All serial inputs are resynchronised into the system clock domain. The serial clock must therefore be slower than the system clock by a margin of a few cycles per half period.

Top module: `spi_reg_slave`

## Requirements
- R1: While reset is asserted, and immediately after it, the summary error flag and all error bits are 0, the output enable is 0 and no register strobe is active. The first reply after reset is 0x0000.
- R2: The slave output enable is 1 while select is low, after a delay of the synchroniser stages. It is 0 again within a few system cycles of select going high.
- R3: A command frame is laid out as bit 15 = direction (1 read, 0 write), bits 14:1 = address, bit 0 = even parity over bits 15:1. For a read of a decoded address, the next frame returns bits 15:2 = register value, bit 1 = summary error flag, bit 0 = even parity over bits 15:1.
- R4: A write command to a decoded address followed by a data frame (bits 15:2 = value, bit 1 ignored, bit 0 = parity) writes the value. The frame after the command returns the old contents and the frame after the data frame returns the new contents.
- R5: A frame whose 16 bits do not have even parity sets error bit 0 and the summary flag. It is not executed, it cancels a pending write, and its reply carries data 0.
- R6: A frame with a clock count other than 16 sets error bit 1 and the summary flag. It is not executed, it cancels a pending write, and its reply carries data 0.
- R7: Any of the following sets error bit 2 and the summary flag, with reply data 0: a read or write of an address the register file does not decode, or a write to the clear or status address.
- R8: The summary flag and the error bits stay set until a read of address 0x3380. That read clears all of them and returns 0x0000.
- R9: The all-zero write command performs no register write and returns 0x0000 when no error is pending.
- R10: A read of address 0x335A returns the error bits in data bits 2:0, with parity in bit 0, clock count in bit 1 and address in bit 2.
- R11: Each executed data frame produces exactly one single-cycle write strobe. The read and write strobes are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| miso_oe | output | 1 | Tri-state enable for miso_o, high while selected |
| reg_addr | output | 14 | Register address presented to the register file |
| reg_wdata | output | 14 | Write data |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_rd | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 14 | Combinational read data for reg_addr |
| reg_hit | input | 1 | High when reg_addr is decoded by the register file |
| comm_err | output | 1 | Sticky summary error flag |
| err_status | output | 3 | Sticky error bits {address, clock count, parity} |

## Verification
The bench builds the block with the default 16-bit frame and the default clear and status addresses, and raises the synchroniser depth to three stages. The deeper synchroniser pushes the edge-to-action latency toward the serial half period, which tests that the one-frame reply pipeline still meets the next frame. With a 16-bit frame, short frames and over-long frames of 15 and 17 clocks are both reachable. Eight decoded registers make both old-value and new-value write replies visible, and they leave most of the address space undecoded for the address-error path.

// File: rtl/spi_rs_pkg.sv
package spi_rs_pkg;

   // Outcome of decoding one finished frame
   typedef enum logic [3:0] {
      K_BADCNT,
      K_BADPAR,
      K_WDATA,
      K_CLR,
      K_STATRD,
      K_EXTRD,
      K_NOP,
      K_WCMD,
      K_BADADDR
   } frame_kind_e;

   typedef enum logic [1:0] {
      S_IDLE,
      S_DRIVE,
      S_CAPT
   } exec_state_e;

   localparam int unsigned ERRB_PAR  = 0;
   localparam int unsigned ERRB_CLK  = 1;
   localparam int unsigned ERRB_ADDR = 2;
   localparam int unsigned ERR_BITS  = 3;

endpackage

// File: rtl/spi_rs_sync.sv
module spi_rs_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= stg[g-1];
         end
      end
   end

   assign q_o = stg[STAGES-1];

endmodule

// File: rtl/spi_rs_shifter.sv
module spi_rs_shifter #(
   parameter int unsigned FRAME_W = 16,
   parameter int unsigned CNT_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sck_s,
   input  logic               cs_n_s,
   input  logic               mosi_s,
   input  logic [FRAME_W-1:0] resp_word,
   output logic [FRAME_W-1:0] rx_word,
   output logic [CNT_W-1:0]   bit_cnt,
   output logic               end_evt,
   output logic               miso_o,
   output logic               miso_oe
);

   logic               sck_q, cs_q;
   logic [FRAME_W-1:0] tx_sh;
   logic               sck_fall, cs_fall;

   assign sck_fall = sck_q & ~sck_s & ~cs_n_s;
   assign cs_fall  = cs_q & ~cs_n_s;
   assign end_evt  = ~cs_q & cs_n_s;
   assign miso_oe  = ~cs_n_s;
   assign miso_o   = miso_oe & tx_sh[FRAME_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q   <= 1'b0;
         cs_q    <= 1'b1;
         tx_sh   <= '0;
         rx_word <= '0;
         bit_cnt <= '0;
      end else begin
         sck_q <= sck_s;
         cs_q  <= cs_n_s;
         if (cs_fall) begin
            tx_sh   <= resp_word;
            bit_cnt <= '0;
         end else if (sck_fall) begin
            tx_sh   <= {tx_sh[FRAME_W-2:0], 1'b0};
            rx_word <= {rx_word[FRAME_W-2:0], mosi_s};
            if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/spi_rs_ctrl.sv
module spi_rs_ctrl
   import spi_rs_pkg::*;
#(
   parameter int unsigned FRAME_W = 16,
   parameter int unsigned CNT_W   = 6,
   parameter logic [FRAME_W-3:0] CLR_ADDR  = 'h3380,
   parameter logic [FRAME_W-3:0] STAT_ADDR = 'h335A
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                end_evt,
   input  logic [FRAME_W-1:0]  rx_word,
   input  logic [CNT_W-1:0]    bit_cnt,
   input  logic [FRAME_W-3:0]  reg_rdata,
   input  logic                reg_hit,
   output logic [FRAME_W-3:0]  reg_addr,
   output logic [FRAME_W-3:0]  reg_wdata,
   output logic                reg_wr,
   output logic                reg_rd,
   output logic [FRAME_W-1:0]  resp_word,
   output logic                comm_err,
   output logic [ERR_BITS-1:0] err_status,
   output logic                clr_evt
);

   localparam int unsigned AW = FRAME_W - 2;

   exec_state_e         state;
   frame_kind_e         kind, dec;
   logic                pend;
   logic [AW-1:0]       wr_addr, cmd_addr;
   logic [AW-1:0]       n_data;
   logic [ERR_BITS-1:0] n_err;
   logic                n_pend, n_ef;

   assign cmd_addr = rx_word[FRAME_W-2:1];

   always_comb begin
      dec = K_NOP;
      if (bit_cnt != CNT_W'(FRAME_W))       dec = K_BADCNT;
      else if (^rx_word)                    dec = K_BADPAR;
      else if (pend)                        dec = K_WDATA;
      else if (rx_word[FRAME_W-1]) begin
         if (cmd_addr == CLR_ADDR)          dec = K_CLR;
         else if (cmd_addr == STAT_ADDR)    dec = K_STATRD;
         else                               dec = K_EXTRD;
      end else begin
         if (cmd_addr == '0)                dec = K_NOP;
         else if (cmd_addr == CLR_ADDR || cmd_addr == STAT_ADDR) dec = K_BADADDR;
         else                               dec = K_WCMD;
      end
   end

   always_comb begin
      n_err  = err_status;
      n_data = '0;
      n_pend = 1'b0;
      unique case (kind)
         K_BADCNT:  n_err[ERRB_CLK] = 1'b1;
         K_BADPAR:  n_err[ERRB_PAR] = 1'b1;
         K_WDATA:   n_data = reg_rdata;
         K_CLR:     n_err = '0;
         K_STATRD:  n_data = AW'(err_status);
         K_EXTRD:   if (reg_hit) n_data = reg_rdata;
                    else         n_err[ERRB_ADDR] = 1'b1;
         K_WCMD:    if (reg_hit) begin
                       n_pend = 1'b1;
                       n_data = reg_rdata;
                    end else n_err[ERRB_ADDR] = 1'b1;
         K_BADADDR: n_err[ERRB_ADDR] = 1'b1;
         default:   n_data = '0;
      endcase
      n_ef = (kind == K_CLR) ? 1'b0 : (comm_err | (|n_err));
   end

   assign clr_evt = (state == S_CAPT) && (kind == K_CLR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         kind       <= K_NOP;
         pend       <= 1'b0;
         wr_addr    <= '0;
         reg_addr   <= '0;
         reg_wdata  <= '0;
         reg_wr     <= 1'b0;
         reg_rd     <= 1'b0;
         resp_word  <= '0;
         comm_err   <= 1'b0;
         err_status <= '0;
      end else begin
         unique case (state)
            S_IDLE: if (end_evt) begin
               kind      <= dec;
               reg_addr  <= (dec == K_WDATA) ? wr_addr : cmd_addr;
               reg_wdata <= rx_word[FRAME_W-1:2];
               reg_wr    <= (dec == K_WDATA);
               reg_rd    <= (dec == K_EXTRD);
               state     <= S_DRIVE;
            end
            S_DRIVE: begin
               reg_wr <= 1'b0;
               reg_rd <= 1'b0;
               state  <= S_CAPT;
            end
            S_CAPT: begin
               err_status <= n_err;
               comm_err   <= n_ef;
               pend       <= n_pend;
               if (n_pend) wr_addr <= reg_addr;
               resp_word  <= {n_data, n_ef, ^{n_data, n_ef}};
               state      <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
   import spi_rs_pkg::*;
#(
   parameter int unsigned FRAME_W     = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [FRAME_W-3:0] CLR_ADDR  = 'h3380,
   parameter logic [FRAME_W-3:0] STAT_ADDR = 'h335A
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                spi_sck,
   input  logic                spi_cs_n,
   input  logic                spi_mosi,
   output logic                miso_o,
   output logic                miso_oe,
   output logic [FRAME_W-3:0]  reg_addr,
   output logic [FRAME_W-3:0]  reg_wdata,
   output logic                reg_wr,
   output logic                reg_rd,
   input  logic [FRAME_W-3:0]  reg_rdata,
   input  logic                reg_hit,
   output logic                comm_err,
   output logic [ERR_BITS-1:0] err_status
);

   localparam int unsigned CNT_W = $clog2(FRAME_W) + 2;

   if (FRAME_W < 8) begin : g_bad_frame
      $error("FRAME_W must be at least 8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CLR_ADDR == STAT_ADDR || CLR_ADDR == '0 || STAT_ADDR == '0) begin : g_bad_addr
      $error("clear and status addresses must differ and be nonzero");
   end

   logic [2:0]         pins_s;
   logic [FRAME_W-1:0] rx_word, resp_word;
   logic [CNT_W-1:0]   bit_cnt;
   logic               end_evt;
   logic               clr_evt;

   spi_rs_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b010)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({spi_sck, spi_cs_n, spi_mosi}),
      .q_o   (pins_s)
   );

   spi_rs_shifter #(
      .FRAME_W (FRAME_W),
      .CNT_W   (CNT_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck_s     (pins_s[2]),
      .cs_n_s    (pins_s[1]),
      .mosi_s    (pins_s[0]),
      .resp_word (resp_word),
      .rx_word   (rx_word),
      .bit_cnt   (bit_cnt),
      .end_evt   (end_evt),
      .miso_o    (miso_o),
      .miso_oe   (miso_oe)
   );

   spi_rs_ctrl #(
      .FRAME_W   (FRAME_W),
      .CNT_W     (CNT_W),
      .CLR_ADDR  (CLR_ADDR),
      .STAT_ADDR (STAT_ADDR)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .end_evt    (end_evt),
      .rx_word    (rx_word),
      .bit_cnt    (bit_cnt),
      .reg_rdata  (reg_rdata),
      .reg_hit    (reg_hit),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .resp_word  (resp_word),
      .comm_err   (comm_err),
      .err_status (err_status),
      .clr_evt    (clr_evt)
   );

endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_wr,
   input logic       reg_rd,
   input logic       ef,
   input logic [2:0] err_status,
   input logic       clr_evt
);

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (!ef && err_status == 3'b000 && !reg_wr && !reg_rd));

   // R11
   wr_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> !reg_wr);

   // R11
   strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({reg_wr, reg_rd}));

   // R8
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ef && !clr_evt) |=> ef);

   // R5
   bits_imply_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_status != 3'b000) |-> ef);

   // R8
   clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_evt |=> (!ef && err_status == 3'b000));

endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_rd     (reg_rd),
   .ef         (comm_err),
   .err_status (err_status),
   .clr_evt    (clr_evt)
);

// File: tb/tb_spi_reg_slave.sv
`timescale 1ns/1ps
module tb_spi_reg_slave;

   localparam int HALF = 6;
   localparam logic [13:0] A_CLR  = 14'h3380;
   localparam logic [13:0] A_STAT = 14'h335A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic        miso_o, miso_oe, reg_wr, reg_rd, reg_hit, comm_err;
   logic [13:0] reg_addr, reg_wdata, reg_rdata;
   logic [2:0]  err_status;

   logic [13:0] rf [8];
   logic [13:0] mm [8];
   logic [13:0] m_pa = '0;
   logic [2:0]  m_err = '0;
   logic        m_ef = 1'b0, m_pend = 1'b0;
   logic [15:0] exp_resp = 16'h0000;
   string       exp_tag = "R1";
   int          n_chk = 0, n_fail = 0, m_wr = 0, hw_wr = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   spi_reg_slave #(.SYNC_STAGES(3)) dut (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
      .miso_o(miso_o), .miso_oe(miso_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .reg_hit(reg_hit),
      .comm_err(comm_err), .err_status(err_status)
   );

   function automatic bit hitf(input logic [13:0] a);
      return a[13:3] == 11'h020;
   endfunction

   assign reg_hit   = hitf(reg_addr);
   assign reg_rdata = reg_hit ? rf[reg_addr[2:0]] : 14'h0;

   always @(posedge clk) if (rst_n && reg_wr) begin
      hw_wr <= hw_wr + 1;
      if (reg_hit) rf[reg_addr[2:0]] <= reg_wdata;
   end

   function automatic logic [15:0] cmdw(input logic rw, input logic [13:0] a);
      return {rw, a, ^{rw, a}};
   endfunction

   function automatic logic [15:0] datw(input logic [13:0] d);
      return {d, 1'b0, ^d};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model(input logic [15:0] w, input int n);
      logic [13:0] a = w[14:1];
      logic [13:0] d = '0;
      if (n != 16) begin m_err[1] = 1'b1; m_ef = 1'b1; m_pend = 1'b0; end
      else if (^w) begin m_err[0] = 1'b1; m_ef = 1'b1; m_pend = 1'b0; end
      else if (m_pend) begin
         mm[m_pa[2:0]] = w[15:2]; m_wr++; d = w[15:2]; m_pend = 1'b0;
      end else if (w[15]) begin
         if (a == A_CLR) begin m_ef = 1'b0; m_err = '0; end
         else if (a == A_STAT) d = {11'd0, m_err};
         else if (hitf(a)) d = mm[a[2:0]];
         else begin m_err[2] = 1'b1; m_ef = 1'b1; end
      end else if (a != 14'h0) begin
         if (hitf(a)) begin m_pend = 1'b1; m_pa = a; d = mm[a[2:0]]; end
         else begin m_err[2] = 1'b1; m_ef = 1'b1; end
      end
      exp_resp = {d, m_ef, ^{d, m_ef}};
   endtask

   task automatic xfer(input logic [15:0] w, input int n, input string tag);
      logic [15:0] got = '0;
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      check("R2 enable while selected", {31'd0, miso_oe}, 32'd1);
      for (int i = 0; i < n; i++) begin
         mosi = (i < 16) ? w[15-i] : 1'b0;
         sck  = 1'b1;
         repeat (HALF) @(negedge clk);
         got  = {got[14:0], miso_o};
         sck  = 1'b0;
         repeat (HALF) @(negedge clk);
      end
      cs_n = 1'b1;
      repeat (14) @(negedge clk);
      check("R2 release after deselect", {31'd0, miso_oe}, 32'd0);
      if (n == 16) check(exp_tag, {16'd0, got}, {16'd0, exp_resp});
      model(w, n);
      exp_tag = tag;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd20250);
      for (int i = 0; i < 8; i++) begin rf[i] = '0; mm[i] = '0; end
      repeat (5) @(negedge clk);
      check("R1 flag in reset", {31'd0, comm_err}, 32'd0);
      check("R1 bits in reset", {29'd0, err_status}, 32'd0);
      check("R1 enable in reset", {31'd0, miso_oe}, 32'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      xfer(16'h0000, 16, "R9 nop reply");
      xfer(16'h0000, 16, "R9 nop reply");
      // R4 write: old then new
      xfer(cmdw(1'b0, 14'h0101), 16, "R4 old contents");
      xfer(datw(14'h2A5C), 16, "R4 new contents");
      xfer(cmdw(1'b1, 14'h0101), 16, "R3 read back");
      xfer(16'h0000, 16, "R9 nop");
      check("R9 no write from nop", hw_wr, 1);

      // random mix
      for (int it = 0; it < 40; it++) begin
         int unsigned op = $urandom % 3;
         logic [13:0] a = 14'h0100 + 14'($urandom % 8);
         if (op == 0) xfer(cmdw(1'b1, a), 16, "R3 random read");
         else if (op == 1) begin
            xfer(cmdw(1'b0, a), 16, "R4 random old");
            xfer(datw(14'($urandom)), 16, "R4 random new");
         end else xfer(16'h0000, 16, "R9 random nop");
      end
      check("R1 no error after clean traffic", {31'd0, comm_err}, 32'd0);

      // R5 bad parity data frame cancels write
      xfer(cmdw(1'b0, 14'h0103), 16, "R4 cmd before bad data");
      xfer(datw(14'h1111) ^ 16'h0001, 16, "R5 bad parity frame");
      check("R5 parity bit set", {29'd0, err_status}, 32'd1);
      check("R5 flag set", {31'd0, comm_err}, 32'd1);
      xfer(cmdw(1'b1, 14'h0103), 16, "R5 register untouched");
      xfer(cmdw(1'b1, A_STAT), 16, "R10 status read");
      xfer(cmdw(1'b1, A_CLR), 16, "R8 clear reply");
      xfer(16'h0000, 16, "R9 nop after clear");
      check("R8 flag cleared", {31'd0, comm_err}, 32'd0);

      // R6 short and long frames
      xfer(cmdw(1'b0, 14'h0102), 15, "R6 short frame");
      check("R6 clock bit set", {29'd0, err_status}, 32'd2);
      xfer(cmdw(1'b0, 14'h0102), 17, "R6 long frame");
      xfer(16'h0000, 16, "R8 nop keeps flag");
      check("R8 flag sticky", {31'd0, comm_err}, 32'd1);
      // R7 unknown addresses
      xfer(cmdw(1'b1, 14'h0200), 16, "R7 unknown read");
      xfer(cmdw(1'b0, A_CLR), 16, "R7 write to clear address");
      check("R7 address bit set", {29'd0, err_status}, 32'd6);
      xfer(cmdw(1'b1, A_STAT), 16, "R10 status all");
      xfer(cmdw(1'b1, A_CLR), 16, "R8 clear reply");
      xfer(16'h0000, 16, "R9 final nop");
      check("R8 bits cleared", {29'd0, err_status}, 32'd0);
      check("R11 one strobe per write", hw_wr, m_wr);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule